// File: doc/BRIEF.md
# Configurable Serial Transmitter with Break

This block turns a stream of bytes into asynchronous serial frames on one output line. Bytes are written into a small first-in first-out store. A frame sequencer takes one byte at a time and sends a start bit, the data bits, an optional parity bit and one or two stop bits. A seven-bit configuration word sets the character length, parity, stop bits, FIFO use and break. A programmable divisor sets the bit rate. The divisor first produces an oversample tick, and sixteen of those ticks make one bit time.

Software writes the divisor as N-1, chooses the frame format and pushes bytes. It can then read three status outputs: FIFO full, transmitter fully idle and shifter busy. With the FIFO turned off, the store holds only one character. A break request drives the line low for as long as it is set. While the transmitter enable is low, the line rests high and any queued bytes stay in place.

Top module: `stx_core`

## Requirements
- R1: `frame_cfg[6:5]` sets the character length: 0 gives 5 data bits, 1 gives 6, 2 gives 7 and 3 gives 8. Data bits above the chosen length are not sent.
- R2: `frame_cfg[1]` set adds a parity bit. With `frame_cfg[2]` set the parity is even (the XOR of the sent data bits); with it clear the parity is odd (the inverse of that XOR).
- R3: `frame_cfg[3]` set sends two stop bits; clear sends one.
- R4: A frame is one low start bit, then the data bits least significant first, then the parity bit if enabled, then the high stop bits.
- R5: Every bit lasts exactly 16*(`baud_div`+1) clock cycles. The start bit appears on `txd` two clock edges after a write into an empty, idle transmitter.
- R6: With `frame_cfg[4]` set the FIFO holds 16 bytes. `fifo_full` is high while 16 bytes are held, and a write made while it is high is dropped.
- R7: With `frame_cfg[4]` clear only one byte is buffered. `fifo_full` is high once it is held, and a second write is dropped.
- R8: `frame_cfg[0]` set drives `txd` low from the next clock edge for as long as it stays set, whether or not the transmitter is enabled. Clearing it returns `txd` to its normal level on the next edge.
- R9: While `tx_enable` is low, `txd` is high unless a break is requested, no frame starts, `shift_busy` is low and queued bytes are kept. They are sent once `tx_enable` returns high.
- R10: `shift_busy` is high while a frame is on the line. `tx_idle` is high exactly when the FIFO is empty and the shifter is not busy.
- R11: After reset `txd` is high, `fifo_full` and `shift_busy` are low, and `tx_idle` is high.
- R12: When a byte is waiting at the end of the last stop bit, its start bit follows on the next cycle with no idle gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_enable | input | 1 | Transmitter enable |
| frame_cfg | input | 7 | Format word: [6:5] length, [4] FIFO on, [3] two stop, [2] even parity, [1] parity on, [0] break |
| baud_div | input | 16 | Divisor minus one for the oversample tick |
| wr_en | input | 1 | Write strobe for one byte |
| wr_byte | input | 8 | Byte to queue |
| txd | output | 1 | Serial line, idles high |
| fifo_full | output | 1 | Store cannot accept another byte |
| tx_idle | output | 1 | Store empty and shifter idle |
| shift_busy | output | 1 | A frame is in progress |

## Verification
On every cycle the assertions check the relations between the line and the controls. A break holds the line low one edge later. A disabled transmitter keeps the line high and the shifter quiet. An idle transmitter never drops the line, every falling edge without a break belongs to a frame in progress, and a full store stays full while sending is stopped. Only the bench scenarios can show the frame contents and bit timing. They sample each bit at its first, middle and last cycle for several formats and divisors. The bench also shows that dropped writes never appear on the line, that a 16-byte burst goes out back to back, and that bypass mode keeps only one byte.

// File: rtl/stx_pkg.sv
package stx_pkg;

    localparam int CFG_W      = 7;
    localparam int CFG_BREAK  = 0;
    localparam int CFG_PAR_ON = 1;
    localparam int CFG_EVEN   = 2;
    localparam int CFG_STOP2  = 3;
    localparam int CFG_FIFO   = 4;
    localparam int CFG_LEN_LO = 5;
    localparam int CFG_LEN_HI = 6;
    localparam int BYTE_W     = 8;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_PARITY,
        PH_STOP
    } tx_phase_e;

    typedef struct packed {
        tx_phase_e         phase;
        logic [BYTE_W-1:0] shreg;
        logic [2:0]        bit_idx;
        logic [3:0]        sub;
        logic [2:0]        last_idx;
        logic              par_bit;
        logic              par_en;
        logic              two_stop;
        logic              line;
        logic              txd;
    } seq_state_t;

    // mask keeping the low 5..8 bits of a byte
    function automatic logic [BYTE_W-1:0] len_mask(input logic [1:0] code);
        return 8'hFF >> (2'd3 - code);
    endfunction

endpackage

// File: rtl/stx_tick_gen.sv
module stx_tick_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_d, cnt_q;
    logic             at_end;

    assign at_end = (cnt_q >= div);
    assign tick   = !clear && at_end;

    always_comb begin
        cnt_d = cnt_q;
        if (clear || at_end) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/stx_fifo.sv
module stx_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fifo_on,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] CAP_DEEP = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] CAP_ONE  = CNT_W'(1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [CNT_W-1:0] count;
    } fifo_state_t;

    fifo_state_t      st_d, st_q;
    logic [W-1:0]     mem [DEPTH];
    logic [CNT_W-1:0] cap;
    logic             do_push, do_pop;

    assign cap     = fifo_on ? CAP_DEEP : CAP_ONE;
    assign full    = (st_q.count >= cap);
    assign empty   = (st_q.count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[st_q.rd_ptr];

    always_comb begin
        st_d = st_q;
        if (do_push) begin
            st_d.wr_ptr = (st_q.wr_ptr == PTR_LAST) ? '0 : st_q.wr_ptr + 1'b1;
        end
        if (do_pop) begin
            st_d.rd_ptr = (st_q.rd_ptr == PTR_LAST) ? '0 : st_q.rd_ptr + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   st_d.count = st_q.count + 1'b1;
            2'b01:   st_d.count = st_q.count - 1'b1;
            default: st_d.count = st_q.count;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[st_q.wr_ptr] <= din;
        end
    end

endmodule

// File: rtl/stx_frame_seq.sv
module stx_frame_seq
    import stx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              brk,
    input  logic [1:0]        len_code,
    input  logic              par_on,
    input  logic              par_even,
    input  logic              two_stop,
    input  logic              tick,
    input  logic              fifo_empty,
    input  logic [BYTE_W-1:0] fifo_dout,
    output logic              pop,
    output logic              txd,
    output logic              busy,
    output logic              tick_clear
);

    seq_state_t        s_d, s_q;
    logic              load_req;
    logic [BYTE_W-1:0] masked;

    assign masked     = fifo_dout & len_mask(len_code);
    assign txd        = s_q.txd;
    assign busy       = (s_q.phase != PH_IDLE);
    assign tick_clear = (s_q.phase == PH_IDLE);

    always_comb begin
        s_d      = s_q;
        load_req = 1'b0;
        pop      = 1'b0;

        if (!enable) begin
            s_d.phase = PH_IDLE;
            s_d.sub   = '0;
            s_d.line  = 1'b1;
        end else if (s_q.phase == PH_IDLE) begin
            s_d.line = 1'b1;
            load_req = !fifo_empty;
        end else if (tick) begin
            if (s_q.sub != 4'hF) begin
                s_d.sub = s_q.sub + 1'b1;
            end else begin
                s_d.sub = '0;
                case (s_q.phase)
                    PH_START: begin
                        s_d.phase   = PH_DATA;
                        s_d.bit_idx = '0;
                        s_d.line    = s_q.shreg[0];
                        s_d.shreg   = s_q.shreg >> 1;
                    end
                    PH_DATA: begin
                        if (s_q.bit_idx == s_q.last_idx) begin
                            s_d.bit_idx = '0;
                            if (s_q.par_en) begin
                                s_d.phase = PH_PARITY;
                                s_d.line  = s_q.par_bit;
                            end else begin
                                s_d.phase = PH_STOP;
                                s_d.line  = 1'b1;
                            end
                        end else begin
                            s_d.bit_idx = s_q.bit_idx + 1'b1;
                            s_d.line    = s_q.shreg[0];
                            s_d.shreg   = s_q.shreg >> 1;
                        end
                    end
                    PH_PARITY: begin
                        s_d.phase   = PH_STOP;
                        s_d.bit_idx = '0;
                        s_d.line    = 1'b1;
                    end
                    PH_STOP: begin
                        if (s_q.two_stop && (s_q.bit_idx == '0)) begin
                            s_d.bit_idx = 3'd1;
                        end else if (!fifo_empty) begin
                            load_req = 1'b1;
                        end else begin
                            s_d.phase = PH_IDLE;
                            s_d.line  = 1'b1;
                        end
                    end
                    default: begin
                        s_d.phase = PH_IDLE;
                        s_d.line  = 1'b1;
                    end
                endcase
            end
        end

        if (load_req) begin
            pop          = 1'b1;
            s_d.phase    = PH_START;
            s_d.shreg    = masked;
            s_d.sub      = '0;
            s_d.bit_idx  = '0;
            s_d.last_idx = {1'b1, len_code};
            s_d.par_en   = par_on;
            s_d.two_stop = two_stop;
            s_d.par_bit  = par_even ? (^masked) : ~(^masked);
            s_d.line     = 1'b0;
        end

        s_d.txd = brk ? 1'b0 : s_d.line;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.phase <= PH_IDLE;
            s_q.line  <= 1'b1;
            s_q.txd   <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/stx_core.sv
module stx_core
    import stx_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int DIV_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_enable,
    input  logic [CFG_W-1:0]  frame_cfg,
    input  logic [DIV_W-1:0]  baud_div,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_byte,
    output logic              txd,
    output logic              fifo_full,
    output logic              tx_idle,
    output logic              shift_busy
);

    logic              tick, tick_clear;
    logic              pop, fifo_empty;
    logic [BYTE_W-1:0] head_byte;

    stx_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (tick_clear),
        .div   (baud_div),
        .tick  (tick)
    );

    stx_fifo #(.DEPTH(FIFO_DEPTH), .W(BYTE_W)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .fifo_on (frame_cfg[CFG_FIFO]),
        .push    (wr_en),
        .din     (wr_byte),
        .pop     (pop),
        .dout    (head_byte),
        .full    (fifo_full),
        .empty   (fifo_empty)
    );

    stx_frame_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (tx_enable),
        .brk        (frame_cfg[CFG_BREAK]),
        .len_code   (frame_cfg[CFG_LEN_HI:CFG_LEN_LO]),
        .par_on     (frame_cfg[CFG_PAR_ON]),
        .par_even   (frame_cfg[CFG_EVEN]),
        .two_stop   (frame_cfg[CFG_STOP2]),
        .tick       (tick),
        .fifo_empty (fifo_empty),
        .fifo_dout  (head_byte),
        .pop        (pop),
        .txd        (txd),
        .busy       (shift_busy),
        .tick_clear (tick_clear)
    );

    assign tx_idle = fifo_empty && !shift_busy;

endmodule

// File: rtl/stx_checker.sv
module stx_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_enable,
    input logic [6:0] frame_cfg,
    input logic       txd,
    input logic       fifo_full,
    input logic       tx_idle,
    input logic       shift_busy
);

    logic past_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            past_ok <= 1'b0;
        end else begin
            past_ok <= 1'b1;
        end
    end

    p_break_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(frame_cfg[0]) |-> !txd);

    p_off_line_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !$past(tx_enable) && !$past(frame_cfg[0]) |-> txd);

    p_off_not_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !$past(tx_enable) |-> !shift_busy);

    p_full_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(fifo_full) && !$past(tx_enable)
        && (frame_cfg[4] == $past(frame_cfg[4])) |-> fifo_full);

    p_fall_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $fell(txd) && !$past(frame_cfg[0]) |-> shift_busy);

    p_idle_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(tx_idle) && !$past(frame_cfg[0]) |-> txd);

endmodule

bind stx_core stx_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_enable  (tx_enable),
    .frame_cfg  (frame_cfg),
    .txd        (txd),
    .fifo_full  (fifo_full),
    .tx_idle    (tx_idle),
    .shift_busy (shift_busy)
);

// File: tb/stx_core_test.sv
module stx_core_test;

    localparam int WDOG = 100000;
    localparam int NV   = 7;
    // {cfg[6:0], data[7:0], divisor[15:0]}
    localparam logic [30:0] VEC [NV] = '{
        {7'b1110000, 8'hA5, 16'd0},
        {7'b1010110, 8'h53, 16'd1},
        {7'b0001010, 8'h1B, 16'd0},
        {7'b0111000, 8'hFF, 16'd2},
        {7'b1110010, 8'h00, 16'd0},
        {7'b1111110, 8'h81, 16'd1},
        {7'b0010000, 8'hE6, 16'd3}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_enable = 1'b0;
    logic [6:0]  frame_cfg = 7'b1110000;
    logic [15:0] baud_div = 16'd0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_byte = 8'h00;
    logic        txd, fifo_full, tx_idle, shift_busy;
    int          checks = 0;
    int          errors = 0;

    always #10 clk = ~clk;

    stx_core uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_enable  (tx_enable),
        .frame_cfg  (frame_cfg),
        .baud_div   (baud_div),
        .wr_en      (wr_en),
        .wr_byte    (wr_byte),
        .txd        (txd),
        .fifo_full  (fifo_full),
        .tx_idle    (tx_idle),
        .shift_busy (shift_busy)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push_byte(input logic [7:0] b);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_byte = b;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // waits for a start bit, then checks first, middle and last cycle of every bit
    task automatic expect_frame(input logic [6:0] cfg, input logic [7:0] d,
                                input int n, input bit chain, input string req);
        logic [11:0] bits;
        logic [7:0]  m;
        int          len, nb, bt, waited;
        len = 5 + int'(cfg[6:5]);
        m   = d & 8'(( 1 << len) - 1);
        bits = '1;
        bits[0] = 1'b0;
        for (int i = 0; i < len; i++) bits[1 + i] = m[i];
        nb = 1 + len;
        if (cfg[1]) begin
            bits[nb] = cfg[2] ? (^m) : ~(^m);
            nb++;
        end
        bits[nb] = 1'b1;
        nb++;
        if (cfg[3]) begin
            bits[nb] = 1'b1;
            nb++;
        end
        bt = 16 * n;
        waited = 0;
        while (txd !== 1'b0 && waited < 5000) begin
            @(negedge clk);
            waited++;
        end
        if (txd !== 1'b0) begin
            chk({req, " R4 start bit"}, 32'(txd), 32'd0);
        end else begin
            for (int t = 0; t < nb * bt; t++) begin
                if ((t % bt) == 0 || (t % bt) == bt / 2 || (t % bt) == bt - 1)
                    chk(req, 32'(txd), 32'(bits[t / bt]));
                if (t == bt / 2)
                    chk("R10 busy during frame", {30'd0, shift_busy, tx_idle}, 32'b10);
                @(negedge clk);
            end
            if (chain)
                chk("R12 next start follows stop", 32'(txd), 32'd0);
            else
                chk("R10 idle after frame", {29'd0, txd, tx_idle, shift_busy}, 32'b110);
        end
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 reset outputs", {28'd0, txd, fifo_full, tx_idle, shift_busy}, 32'b1010);

        // table of formats and divisors: R1 R2 R3 R4 R5
        for (int v = 0; v < NV; v++) begin
            frame_cfg = VEC[v][30:24];
            baud_div  = VEC[v][15:0];
            tx_enable = 1'b1;
            push_byte(VEC[v][23:16]);
            expect_frame(VEC[v][30:24], VEC[v][23:16], int'(VEC[v][15:0]) + 1, 1'b0,
                         "R1 R2 R3 R4 R5 frame bit");
        end

        // R6 and R9: fill 16 bytes while disabled, 17th dropped
        tx_enable = 1'b0;
        frame_cfg = 7'b1110000;
        baud_div  = 16'd0;
        for (int i = 0; i < 15; i++) push_byte(8'h10 + 8'(i));
        chk("R6 not full at 15", 32'(fifo_full), 32'd0);
        push_byte(8'h1F);
        chk("R6 full at 16", 32'(fifo_full), 32'd1);
        push_byte(8'hEE);
        repeat (100) @(negedge clk);
        chk("R9 disabled line and status", {29'd0, txd, shift_busy, tx_idle}, 32'b100);
        tx_enable = 1'b1;
        for (int i = 0; i < 16; i++)
            expect_frame(7'b1110000, 8'h10 + 8'(i), 1, (i < 15), "R6 R9 R12 queued byte");

        // R7 bypass mode: one byte only
        tx_enable = 1'b0;
        frame_cfg = 7'b1100000;
        push_byte(8'h3C);
        chk("R7 full with one byte", 32'(fifo_full), 32'd1);
        push_byte(8'hC3);
        tx_enable = 1'b1;
        expect_frame(7'b1100000, 8'h3C, 1, 1'b0, "R7 held byte");

        // R8 break while enabled and while disabled
        frame_cfg = 7'b1110001;
        @(negedge clk);
        chk("R8 break low", 32'(txd), 32'd0);
        repeat (50) @(negedge clk);
        chk("R8 break held", 32'(txd), 32'd0);
        tx_enable = 1'b0;
        repeat (5) @(negedge clk);
        chk("R8 break while disabled", 32'(txd), 32'd0);
        frame_cfg = 7'b1110000;
        @(negedge clk);
        chk("R8 break released", 32'(txd), 32'd1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule